// File: doc/BRIEF.md
# Synchronous Burst Memory Controller

This block is the master side of a link to clocked SRAM-style memories and to synchronous FIFOs. A client asks for a burst with a single request that gives the direction, the start address and the beat count. The controller then issues one command per clock on consecutive cycles. It asks the client for each beat's data and byte-enable value through a take strobe. On the memory side it drives an active-low chip enable, a shared strobe, an output enable, a write enable, an address and active-low byte enables. Read words come back to the client with a valid flag, and a completion pulse follows the final beat.

A configuration word is sampled when each request is accepted. It sets the read capture delay (0 to 3 cycles), the write data delay (0 to 3 cycles), whether chip enable is stretched across the read tail, and whether the strobe acts as an address strobe with a deselect cycle or as a FIFO read enable with no deselect. It also holds a one-bit output-clock choice that is presented on a port for the clocking logic outside this block.

Top module: `sync_mem_ctrl`

## Requirements
- R1: While and after reset, `mem_ce_n`, `mem_strobe_n`, `mem_oe_n` and `mem_we_n` are 1, `req_ready` is 1, and `rd_valid`, `done` and `mem_dout_en` are 0.
- R2: For a read command presented in cycle t with read delay RL, `mem_din` is sampled at the end of cycle t+RL and appears on `rd_data` with `rd_valid`=1 in cycle t+RL+1. Words return in command order.
- R3: For a write command presented in cycle t with write delay WL, that beat's data is on `mem_dout` with `mem_dout_en`=1 in cycle t+WL, and `mem_dout_en` is 0 in all other cycles.
- R4: With the stretch bit at 0, and for every write, `mem_ce_n` is 0 exactly in the command cycles and returns to 1 in the cycle after the last command.
- R5: With the stretch bit at 1, `mem_ce_n` on a read stays 0 for as long as `mem_oe_n` is 0, through the last capture cycle.
- R6: With the strobe-mode bit at 0, `mem_strobe_n` is 0 in every command cycle, read or write. After the latency tail it is 0 for exactly one more cycle with `mem_ce_n`=1 (a deselect), before a new request can be accepted.
- R7: With the strobe-mode bit at 1, `mem_strobe_n` is 0 only in read command cycles, no deselect cycle is added, and `req_ready` returns in the cycle after the tail.
- R8: A burst of `req_len`+1 beats puts commands on consecutive cycles. The address starts at `req_addr` and increments by one per command, wrapping modulo 2^AW. `mem_be_n` of each command is the inverse of the `beat_be` value taken for that beat, and it is all ones outside command cycles. `beat_take` is 1 in the cycle before each command, when `beat_data` and `beat_be` are consumed. `mem_we_n` is 0 exactly in write command cycles.
- R9: `mem_oe_n` is 0 from the first read command until the last capture cycle, and it is never 0 during a write burst.
- R10: Configuration inputs are sampled only at request acceptance. Changes during a burst alter neither the burst in flight nor `mem_clk_sel`.
- R11: `req_ready` is 1 only when idle, and a request is accepted when `req_valid` and `req_ready` are both 1. `done` pulses for one cycle: on a read, in the cycle after the final `rd_valid`; on a write, in the cycle after the final write data cycle.
- R12: `mem_clk_sel` shows the clock-choice bit captured at the most recent acceptance, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_lat | input | 2 | Read capture delay, 0..3 |
| cfg_wr_lat | input | 2 | Write data delay, 0..3 |
| cfg_ce_ext | input | 1 | 1: stretch chip enable over the read tail |
| cfg_fifo_mode | input | 1 | 1: strobe is a FIFO read enable, no deselect |
| cfg_clk_sel | input | 1 | Output-clock choice to be stored |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1: write burst, 0: read burst |
| req_addr | input | AW | Start address |
| req_len | input | LW | Beat count minus one |
| beat_take | output | 1 | Current beat data and byte enables consumed at this edge |
| beat_data | input | DW | Write data for the current beat |
| beat_be | input | DW/8 | Byte enables for the current beat (active high) |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |
| done | output | 1 | Burst completion pulse |
| mem_clk_sel | output | 1 | Stored output-clock choice |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_strobe_n | output | 1 | Address strobe or FIFO read enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Command address |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_dout | output | DW | Write data to memory |
| mem_dout_en | output | 1 | Write data bus driven |
| mem_din | input | DW | Read data from memory |

## Verification
In FIFO strobe mode there is no deselect cycle. A request can therefore be accepted right after the previous read's tail, and the completion pulse of the earlier burst falls in the same cycle as the first command of the next one. The bench holds `req_valid` high through a short read burst so that the second request is taken at the first idle edge. It then checks in that one cycle that `done` is high while chip enable, the strobe and the new start address show the second command. It also checks that the second burst's data returns without stale capture tags from the first.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int LAT_W   = 2;
  localparam int MAX_LAT = (1 << LAT_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_TAIL,
    ST_DESEL
  } smc_state_e;

  typedef struct packed {
    logic [LAT_W-1:0] rd_lat;
    logic [LAT_W-1:0] wr_lat;
    logic             ce_ext;
    logic             fifo_mode;
    logic             clk_sel;
  } smc_cfg_t;
endpackage

// File: rtl/smc_lat_pipe.sv
module smc_lat_pipe
  import smc_pkg::*;
#(
  parameter int W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [W-1:0]     din,
  input  logic [LAT_W-1:0] sel,
  output logic [W-1:0]     dout
);
  logic [W-1:0] dly [1:MAX_LAT];

  always_ff @(posedge clk) begin
    if (rst || flush) dly[1] <= '0;
    else              dly[1] <= din;
  end

  for (genvar g = 2; g <= MAX_LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || flush) dly[g] <= '0;
      else              dly[g] <= dly[g-1];
    end
  end

  always_comb begin
    dout = din;
    for (int k = 1; k <= MAX_LAT; k++)
      if (sel == LAT_W'(k)) dout = dly[k];
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_len,
  input  logic [LAT_W-1:0] tail_len,
  input  logic             no_desel,
  output logic             req_ready,
  output logic             accept,
  output smc_state_e       state,
  output logic [AW-1:0]    addr_cnt,
  output logic             last_beat
);
  logic [LW-1:0]    beats_left;
  logic [LAT_W-1:0] tail_left;
  smc_state_e       after_burst;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_ready && req_valid;
  assign last_beat   = (state == ST_ISSUE) && (beats_left == '0);
  assign after_burst = no_desel ? ST_IDLE : ST_DESEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      tail_left  <= '0;
      addr_cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state      <= ST_ISSUE;
          beats_left <= req_len;
          addr_cnt   <= req_addr;
        end
        ST_ISSUE: begin
          addr_cnt <= addr_cnt + 1'b1;
          if (beats_left == '0) begin
            if (tail_len != '0) begin
              tail_left <= tail_len - 1'b1;
              state     <= ST_TAIL;
            end else begin
              state <= after_burst;
            end
          end else begin
            beats_left <= beats_left - 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_left == '0) state <= after_burst;
          else                 tail_left <= tail_left - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ISSUE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> (state == ST_ISSUE)); // R11
endmodule

// File: rtl/sync_mem_ctrl.sv
module sync_mem_ctrl
  import smc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LAT_W-1:0]  cfg_rd_lat,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic              cfg_ce_ext,
  input  logic              cfg_fifo_mode,
  input  logic              cfg_clk_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [LW-1:0]     req_len,
  output logic              beat_take,
  input  logic [DW-1:0]     beat_data,
  input  logic [DW/8-1:0]   beat_be,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              mem_clk_sel,
  output logic              mem_ce_n,
  output logic              mem_strobe_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dout_en,
  input  logic [DW-1:0]     mem_din
);
  localparam int BW  = DW / 8;
  localparam int WPW = DW + 2;

  smc_cfg_t         cfg_in, cfg_q;
  logic             wr_q;
  smc_state_e       state;
  logic             accept, last_beat;
  logic [AW-1:0]    addr_cnt;
  logic [LAT_W-1:0] tail_len;
  logic             issuing, tailing, desel;

  assign cfg_in = '{rd_lat: cfg_rd_lat, wr_lat: cfg_wr_lat, ce_ext: cfg_ce_ext,
                    fifo_mode: cfg_fifo_mode, clk_sel: cfg_clk_sel};
  assign tail_len = wr_q ? cfg_q.wr_lat : cfg_q.rd_lat;

  smc_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .tail_len  (tail_len),
    .no_desel  (cfg_q.fifo_mode),
    .req_ready (req_ready),
    .accept    (accept),
    .state     (state),
    .addr_cnt  (addr_cnt),
    .last_beat (last_beat)
  );

  assign issuing     = (state == ST_ISSUE);
  assign tailing     = (state == ST_TAIL);
  assign desel       = (state == ST_DESEL);
  assign beat_take   = issuing;
  assign mem_clk_sel = cfg_q.clk_sel;

  // command stage: everything toward the memory leaves a register
  logic          rd_tag0, rd_last0, wr_en0, wr_last0;
  logic [DW-1:0] wr_d0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q        <= '0;
      wr_q         <= 1'b0;
      mem_ce_n     <= 1'b1;
      mem_strobe_n <= 1'b1;
      mem_oe_n     <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_addr     <= '0;
      mem_be_n     <= '1;
      rd_tag0      <= 1'b0;
      rd_last0     <= 1'b0;
      wr_en0       <= 1'b0;
      wr_last0     <= 1'b0;
      wr_d0        <= '0;
    end else begin
      if (accept) begin
        cfg_q <= cfg_in;
        wr_q  <= req_write;
      end
      mem_ce_n     <= !(issuing || (tailing && !wr_q && cfg_q.ce_ext));
      mem_strobe_n <= cfg_q.fifo_mode ? !(issuing && !wr_q) : !(issuing || desel);
      mem_oe_n     <= !((issuing || tailing) && !wr_q);
      mem_we_n     <= !(issuing && wr_q);
      if (issuing) mem_addr <= addr_cnt;
      mem_be_n     <= issuing ? ~beat_be : {BW{1'b1}};
      rd_tag0      <= issuing && !wr_q;
      rd_last0     <= last_beat && !wr_q;
      wr_en0       <= issuing && wr_q;
      wr_last0     <= last_beat && wr_q;
      if (issuing) wr_d0 <= beat_data;
    end
  end

  // latency alignment for capture tags and write data
  logic [1:0]     rd_pipe_out;
  logic [WPW-1:0] wr_pipe_out;
  logic           rd_cap, rd_cap_last, wr_out_en, wr_out_last;

  smc_lat_pipe #(.W(2)) u_rd_pipe (
    .clk   (clk),
    .rst   (rst),
    .flush (accept),
    .din   ({rd_tag0, rd_last0}),
    .sel   (cfg_q.rd_lat),
    .dout  (rd_pipe_out)
  );

  smc_lat_pipe #(.W(WPW)) u_wr_pipe (
    .clk   (clk),
    .rst   (rst),
    .flush (accept),
    .din   ({wr_en0, wr_last0, wr_d0}),
    .sel   (cfg_q.wr_lat),
    .dout  (wr_pipe_out)
  );

  assign {rd_cap, rd_cap_last}               = rd_pipe_out;
  assign {wr_out_en, wr_out_last, mem_dout}  = wr_pipe_out;
  assign mem_dout_en                         = wr_out_en;

  // capture and completion
  logic rd_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_last_q <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      rd_valid  <= rd_cap;
      rd_last_q <= rd_cap && rd_cap_last;
      if (rd_cap) rd_data <= mem_din;
      done      <= (rd_valid && rd_last_q) || (wr_out_en && wr_out_last);
    end
  end

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> mem_oe_n); // R9
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> !mem_ce_n); // R4
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst) !req_ready |=> $stable(cfg_q)); // R10
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R11
  AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(!mem_oe_n)); // R2
  AST_FIFO_NO_DESEL: assert property (@(posedge clk) disable iff (rst) (cfg_q.fifo_mode && !mem_strobe_n) |-> !mem_ce_n); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
endmodule

// File: tb/test_sync_mem_ctrl.sv
`timescale 1ns/1ps
module test_sync_mem_ctrl;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_rd_lat = '0, cfg_wr_lat = '0;
  logic          cfg_ce_ext = 1'b0, cfg_fifo_mode = 1'b0, cfg_clk_sel = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          beat_take;
  logic [DW-1:0] beat_data = '0;
  logic [BW-1:0] beat_be = '0;
  logic          rd_valid, done, mem_clk_sel;
  logic [DW-1:0] rd_data, mem_dout;
  logic          mem_ce_n, mem_strobe_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_be_n;
  logic [DW-1:0] mem_din = '0;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sync_mem_ctrl #(.AW(AW), .DW(DW), .LW(LW)) i_sync_mem_ctrl (
    .clk(clk), .rst(rst),
    .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat), .cfg_ce_ext(cfg_ce_ext),
    .cfg_fifo_mode(cfg_fifo_mode), .cfg_clk_sel(cfg_clk_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len),
    .beat_take(beat_take), .beat_data(beat_data), .beat_be(beat_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .mem_clk_sel(mem_clk_sel),
    .mem_ce_n(mem_ce_n), .mem_strobe_n(mem_strobe_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] din_at(int k, int salt);
    return DW'(16'h3A00 + k * 37 + salt);
  endfunction
  function automatic logic [DW-1:0] pat(int i);
    return DW'(16'hB100 + i * 16'h0203);
  endfunction
  function automatic logic [BW-1:0] be_of(int i);
    return BW'((i % 3) + 1);
  endfunction

  // One burst, checked cycle by cycle; k=0 is the first cycle after acceptance.
  task automatic run_burst(input bit wr, input int addr, input int len, input int rl, input int wl,
                           input bit ext, input bit fifo, input bit sel, input bit scramble, input int salt);
    int L, T;
    L = len + 1;
    T = wr ? wl : rl;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_rd_lat = 2'(rl); cfg_wr_lat = 2'(wl); cfg_ce_ext = ext; cfg_fifo_mode = fifo;
    cfg_clk_sel = sel;
    req_write = wr; req_addr = AW'(addr); req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= L + T + 3; k++) begin
      bit cmd, e_ce, e_oe, e_we, e_st, e_den, e_rv, e_done, e_rdy;
      if (k == 0) req_valid = 1'b0;
      if (scramble && k == 1) begin // R10: inputs change mid-burst
        cfg_rd_lat = ~cfg_rd_lat; cfg_wr_lat = ~cfg_wr_lat; cfg_ce_ext = ~ext;
        cfg_fifo_mode = ~fifo; cfg_clk_sel = ~sel;
      end
      cmd    = (k >= 1 && k <= L);
      e_ce   = cmd || (!wr && ext && k >= L + 1 && k <= L + rl);
      e_oe   = !wr && k >= 1 && k <= L + rl;
      e_we   = wr && cmd;
      e_st   = fifo ? (!wr && cmd) : (cmd || k == L + T + 1);
      e_den  = wr && k >= 1 + wl && k <= L + wl;
      e_rv   = !wr && k >= 2 + rl && k <= L + rl + 1;
      e_done = (k == (wr ? L + wl + 1 : L + rl + 2));
      e_rdy  = (k >= (fifo ? L + T : L + T + 1));
      chk("R8", "beat_take", beat_take, (k < L));
      chk((!wr && ext) ? "R5" : "R4", "mem_ce_n", mem_ce_n, !e_ce);
      chk("R9", "mem_oe_n", mem_oe_n, !e_oe);
      chk("R8", "mem_we_n", mem_we_n, !e_we);
      chk(fifo ? "R7" : "R6", "mem_strobe_n", mem_strobe_n, !e_st);
      if (cmd) begin
        chk("R8", "mem_addr", mem_addr, (addr + k - 1) & ((1 << AW) - 1));
        chk("R8", "mem_be_n", mem_be_n, BW'(~be_of(k - 1)));
      end else begin
        chk("R8", "mem_be_n idle", mem_be_n, (1 << BW) - 1);
      end
      chk("R3", "mem_dout_en", mem_dout_en, e_den);
      if (e_den) chk("R3", "mem_dout", mem_dout, pat(k - 1 - wl));
      chk("R2", "rd_valid", rd_valid, e_rv);
      if (e_rv) chk("R2", "rd_data", rd_data, din_at(k - 1, salt));
      chk("R11", "done", done, e_done);
      chk("R11", "req_ready", req_ready, e_rdy);
      chk(scramble ? "R10" : "R12", "mem_clk_sel", mem_clk_sel, sel);
      beat_data = pat(k);
      beat_be   = be_of(k);
      mem_din   = din_at(k, salt);
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk("R1", "mem_ce_n", mem_ce_n, 1);
    chk("R1", "mem_strobe_n", mem_strobe_n, 1);
    chk("R1", "mem_oe_n", mem_oe_n, 1);
    chk("R1", "mem_we_n", mem_we_n, 1);
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mem_dout_en", mem_dout_en, 0);
    chk("R12", "mem_clk_sel", mem_clk_sel, 0);
  endtask

  // R11/R7: done of one read burst meets the first command of the next
  task automatic test_back_to_back();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_rd_lat = 2'd1; cfg_wr_lat = 2'd0; cfg_ce_ext = 1'b0; cfg_fifo_mode = 1'b1;
    cfg_clk_sel = 1'b0;
    req_write = 1'b0; req_addr = AW'(12'h100); req_len = LW'(1); req_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= 9; k++) begin
      if (k == 0) req_addr = AW'(12'h200);
      if (k == 0) req_len = LW'(0);
      if (k == 4) req_valid = 1'b0;
      if (k == 1 || k == 2) chk("R11", "b2b req_ready busy", req_ready, 0);
      if (k == 3) chk("R7", "b2b req_ready no deselect", req_ready, 1);
      if (k == 4) chk("R2", "b2b first burst last word", rd_data, din_at(3, 0));
      if (k == 5) begin
        chk("R11", "b2b done", done, 1);
        chk("R8", "b2b next mem_ce_n", mem_ce_n, 0);
        chk("R7", "b2b next mem_strobe_n", mem_strobe_n, 0);
        chk("R8", "b2b next mem_addr", mem_addr, 12'h200);
        chk("R2", "b2b no stale rd_valid", rd_valid, 0);
      end
      if (k == 6) chk("R2", "b2b rd_valid gap", rd_valid, 0);
      if (k == 7) begin
        chk("R2", "b2b second rd_valid", rd_valid, 1);
        chk("R2", "b2b second rd_data", rd_data, din_at(6, 0));
      end
      if (k == 8) chk("R11", "b2b second done", done, 1);
      beat_data = pat(k);
      beat_be   = be_of(k);
      mem_din   = din_at(k, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_burst(0, 12'h040, 0, 0, 0, 0, 0, 0, 0, 3);   // read, no delay
    run_burst(0, 12'h123, 3, 2, 0, 0, 0, 1, 0, 11);  // read, delay 2
    run_burst(0, 12'h500, 2, 3, 0, 1, 0, 0, 0, 20);  // read, stretched CE
    run_burst(0, 12'h0A0, 1, 1, 0, 1, 1, 1, 0, 5);   // read, FIFO strobe
    run_burst(1, 12'h210, 2, 0, 0, 0, 0, 0, 0, 0);   // write, no delay
    run_burst(1, 12'h333, 1, 0, 3, 1, 1, 1, 0, 0);   // write, delay 3, FIFO strobe
    run_burst(1, 12'hFFE, 15, 1, 2, 0, 0, 0, 0, 0);  // long write across wrap
    run_burst(0, 12'h7F0, 2, 2, 1, 0, 0, 1, 1, 9);   // cfg changed mid-burst
    run_burst(1, 12'h050, 1, 3, 1, 0, 1, 0, 1, 0);   // cfg changed mid-burst, write
    test_back_to_back();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R11 watchdog: actual no completion expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule